// File: doc/BRIEF.md
# Predicate Write Merge Log

This block collects the predicate results produced while one instruction packet executes and applies them to the architectural predicate file only when the packet retires. It holds a small set of 8-bit predicate registers. Two write ports can each name a predicate index and a value in any cycle. Only the low byte of each value is kept.

The first write to a predicate in a packet stores the value and marks that predicate as pending. Any further write to the same predicate in the same packet is combined with the stored byte by a bitwise AND, so the last write does not simply win. When both ports name the same predicate in one cycle, both values are ANDed in. A commit strobe copies the pending bytes into the architectural registers. Only predicates that were written are changed. The commit also empties the log, so the next packet starts clean.

Writes presented in the commit cycle still belong to the packet being closed. Two registered read ports return committed values only. A pending value is not visible on them until its commit has taken effect.

Top module: `pred_merge_log`

## Requirements
- R1: While `rst` is high at a clock edge, all architectural predicates, pending bytes and the pending mask become zero. After that edge, `pend_mask` reads 0 and both read ports return 0.
- R2: A valid write to predicate n that has no pending entry stores bits [7:0] of the write data. It also sets bit n of `pend_mask`, and that bit is seen one cycle after the write.
- R3: A valid write to predicate n that already has a pending entry replaces the stored byte with the bitwise AND of the stored byte and the new low byte.
- R4: When both write ports are valid and name the same predicate in one cycle, the pending result is the AND of both low bytes. If an entry was already pending, its byte is ANDed in as well.
- R5: When both write ports are valid and name different predicates, both predicates receive their values in that cycle.
- R6: On commit, each predicate whose mask bit is set, or that is written in the commit cycle, takes its merged byte. Every other predicate keeps its committed value.
- R7: Commit clears `pend_mask` and the pending bytes at the same edge. A write in the next packet is stored fresh and is not ANDed with the previous packet's value.
- R8: A write presented in the same cycle as `commit` is merged into the packet being committed.
- R9: Each read port returns, one cycle after its index is presented, the committed value of that predicate as it stood before that edge. Pending values never appear on the read ports.
- R10: A write port whose valid input is low changes no pending byte, no mask bit and no committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wa_vld | input | 1 | Write port A valid |
| wa_idx | input | 2 | Write port A predicate index |
| wa_data | input | 32 | Write port A value; only bits [7:0] are kept |
| wb_vld | input | 1 | Write port B valid |
| wb_idx | input | 2 | Write port B predicate index |
| wb_data | input | 32 | Write port B value; only bits [7:0] are kept |
| commit | input | 1 | Packet retire strobe |
| rd0_idx | input | 2 | Read port 0 predicate index |
| rd0_data | output | 8 | Read port 0 committed value, registered |
| rd1_idx | input | 2 | Read port 1 predicate index |
| rd1_data | output | 8 | Read port 1 committed value, registered |
| pend_mask | output | 4 | Pending mask; bit n is set when predicate n holds a pending value |

## Verification
A pending byte that is not merged correctly stays hidden until commit. It shows on a read port two cycles after the commit edge is driven: one cycle for the commit and one for the registered read. The bench therefore reads back every predicate after each directed commit. A mask bit that sticks or is lost shows on `pend_mask` at the very next cycle. A stuck bit also shows later, as a stale AND against the previous packet's value (R7). During the random phase, every cycle compares the mask and both read ports against a reference model, so any divergence shows within a few cycles.

// File: rtl/pred_log_pkg.sv
package pred_log_pkg;
  localparam int NUM_PRED = 4;
  localparam int PRED_W   = 8;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = $clog2(NUM_PRED);
  localparam int NUM_WP   = 2;
  localparam int NUM_RP   = 2;

  typedef logic [PRED_W-1:0] pbyte_t;
endpackage

// File: rtl/pred_wr_merge.sv
module pred_wr_merge #(
  parameter int NP  = 4,
  parameter int PW  = 8,
  parameter int NWP = 2,
  localparam int IW = $clog2(NP)
) (
  input  logic [NP-1:0][PW-1:0]  pend_q,
  input  logic [NP-1:0]          mask_q,
  input  logic [NWP-1:0]         wvld,
  input  logic [NWP-1:0][IW-1:0] widx,
  input  logic [NWP-1:0][PW-1:0] wdat,
  output logic [NP-1:0][PW-1:0]  merged,
  output logic [NP-1:0]          touched
);
  for (genvar n = 0; n < NP; n++) begin : g_ent
    logic [NWP-1:0] hit;
    logic [PW-1:0]  acc;

    always_comb begin
      for (int p = 0; p < NWP; p++) begin
        hit[p] = wvld[p] && (widx[p] == IW'(n));
      end
      acc = mask_q[n] ? pend_q[n] : {PW{1'b1}};
      for (int p = 0; p < NWP; p++) begin
        if (hit[p]) acc = acc & wdat[p];
      end
    end

    assign touched[n] = mask_q[n] | (|hit);
    assign merged[n]  = touched[n] ? acc : pend_q[n];
  end
endmodule

// File: rtl/pred_pend_store.sv
module pred_pend_store #(
  parameter int NP = 4,
  parameter int PW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commit,
  input  logic [NP-1:0][PW-1:0] merged,
  input  logic [NP-1:0]         touched,
  output logic [NP-1:0][PW-1:0] pend_q,
  output logic [NP-1:0]         mask_q
);
  always_ff @(posedge clk) begin
    if (rst || commit) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= merged;
      mask_q <= touched;
    end
  end

  // R7
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (mask_q == '0));

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (pend_q == '0));
endmodule

// File: rtl/pred_arch_file.sv
module pred_arch_file #(
  parameter int NP  = 4,
  parameter int PW  = 8,
  parameter int NRP = 2,
  localparam int IW = $clog2(NP)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   commit,
  input  logic [NP-1:0]          upd,
  input  logic [NP-1:0][PW-1:0]  merged,
  input  logic [NRP-1:0][IW-1:0] ridx,
  output logic [NRP-1:0][PW-1:0] rdat
);
  logic [NP-1:0][PW-1:0] arch_q;
  logic                  past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  for (genvar n = 0; n < NP; n++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                  arch_q[n] <= '0;
      else if (commit && upd[n]) arch_q[n] <= merged[n];
    end

    // R6
    keep_unwritten_chk: assert property (@(posedge clk) disable iff (rst)
      !(commit && upd[n]) |=> $stable(arch_q[n]));
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) rdat[p] <= '0;
      else     rdat[p] <= arch_q[ridx[p]];
    end

    // R9
    read_committed_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
      1'b1 |=> (rdat[p] == $past(arch_q[ridx[p]])));
  end
endmodule

// File: rtl/pred_merge_log.sv
module pred_merge_log
  import pred_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_vld,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_vld,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              commit,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [PRED_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [PRED_W-1:0] rd1_data,
  output logic [NUM_PRED-1:0] pend_mask
);
  logic [NUM_WP-1:0]              wvld;
  logic [NUM_WP-1:0][IDX_W-1:0]   widx;
  logic [NUM_WP-1:0][PRED_W-1:0]  wdat;
  logic [NUM_PRED-1:0][PRED_W-1:0] pend_q;
  logic [NUM_PRED-1:0][PRED_W-1:0] merged;
  logic [NUM_PRED-1:0]            mask_q;
  logic [NUM_PRED-1:0]            touched;
  logic [NUM_RP-1:0][IDX_W-1:0]   ridx;
  logic [NUM_RP-1:0][PRED_W-1:0]  rdat;

  assign wvld = {wb_vld, wa_vld};
  assign widx = {wb_idx, wa_idx};
  assign wdat = {wb_data[PRED_W-1:0], wa_data[PRED_W-1:0]};
  assign ridx = {rd1_idx, rd0_idx};

  pred_wr_merge #(.NP(NUM_PRED), .PW(PRED_W), .NWP(NUM_WP)) u_merge (
    .pend_q(pend_q), .mask_q(mask_q), .wvld(wvld), .widx(widx), .wdat(wdat),
    .merged(merged), .touched(touched)
  );

  pred_pend_store #(.NP(NUM_PRED), .PW(PRED_W)) u_pend (
    .clk(clk), .rst(rst), .commit(commit), .merged(merged), .touched(touched),
    .pend_q(pend_q), .mask_q(mask_q)
  );

  pred_arch_file #(.NP(NUM_PRED), .PW(PRED_W), .NRP(NUM_RP)) u_arch (
    .clk(clk), .rst(rst), .commit(commit), .upd(touched), .merged(merged),
    .ridx(ridx), .rdat(rdat)
  );

  assign rd0_data  = rdat[0];
  assign rd1_data  = rdat[1];
  assign pend_mask = mask_q;

  // R2
  first_write_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (wa_vld && !commit) |=> pend_mask[$past(wa_idx)]);

  // R3
  and_only_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wa_vld && pend_mask[wa_idx] && !commit) |=>
      ((pend_q[$past(wa_idx)] & ~$past(pend_q[wa_idx])) == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wa_vld && !wb_vld && !commit) |=> ($stable(pend_mask) && $stable(pend_q)));
endmodule

// File: tb/sim_pred_merge_log.sv
module sim_pred_merge_log;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wa_vld = 0, wb_vld = 0, commit = 0;
  logic [1:0] wa_idx = 0, wb_idx = 0, rd0_idx = 0, rd1_idx = 0;
  logic [31:0] wa_data = 0, wb_data = 0;
  logic [7:0] rd0_data, rd1_data;
  logic [3:0] pend_mask;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] m_arch [4];
  logic [7:0] m_pend [4];
  logic [3:0] m_mask;
  logic [7:0] e_rd0, e_rd1;

  always #5 clk = ~clk;

  pred_merge_log u0 (
    .clk(clk), .rst(rst),
    .wa_vld(wa_vld), .wa_idx(wa_idx), .wa_data(wa_data),
    .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_data(wb_data),
    .commit(commit),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .pend_mask(pend_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [7:0] acc;
    logic hit;
    e_rd0 = m_arch[rd0_idx];
    e_rd1 = m_arch[rd1_idx];
    for (int n = 0; n < 4; n++) begin
      acc = m_mask[n] ? m_pend[n] : 8'hFF;
      hit = 1'b0;
      if (wa_vld && wa_idx == n[1:0]) begin acc &= wa_data[7:0]; hit = 1'b1; end
      if (wb_vld && wb_idx == n[1:0]) begin acc &= wb_data[7:0]; hit = 1'b1; end
      if (commit) begin
        if (m_mask[n] || hit) m_arch[n] = acc;
      end else if (m_mask[n] || hit) begin
        m_pend[n] = acc;
        m_mask[n] = 1'b1;
      end
    end
    if (commit) begin
      m_mask = '0;
      for (int n = 0; n < 4; n++) m_pend[n] = '0;
    end
  endtask

  task automatic step(input logic av, input logic [1:0] ai, input logic [31:0] ad,
                      input logic bv, input logic [1:0] bi, input logic [31:0] bd,
                      input logic cm, input logic [1:0] r0, input logic [1:0] r1);
    @(negedge clk);
    wa_vld = av; wa_idx = ai; wa_data = ad;
    wb_vld = bv; wb_idx = bi; wb_data = bd;
    commit = cm; rd0_idx = r0; rd1_idx = r1;
    @(posedge clk);
    model_edge();
    #1;
    chk("R2 mask model", {28'd0, pend_mask}, {28'd0, m_mask});
    chk("R9 rd0 model", {24'd0, rd0_data}, {24'd0, e_rd0});
    chk("R9 rd1 model", {24'd0, rd1_data}, {24'd0, e_rd1});
  endtask

  task automatic nop(); step(0,0,0, 0,0,0, 0,0,0); endtask

  task automatic rdchk(input string tag, input logic [1:0] idx, input logic [7:0] exp);
    step(0,0,0, 0,0,0, 0, idx, idx);
    chk(tag, {24'd0, rd0_data}, {24'd0, exp});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    for (int n = 0; n < 4; n++) begin m_arch[n] = 0; m_pend[n] = 0; end
    m_mask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    #1 chk("R1 mask after reset", {28'd0, pend_mask}, 32'd0);
    rdchk("R1 read p0", 2'd0, 8'h00);
    rdchk("R1 read p3", 2'd3, 8'h00);
    // R2 first write keeps low byte
    step(1,2'd1,32'h1234_56A5, 0,0,0, 0,0,0);
    chk("R2 mask bit1", {28'd0, pend_mask}, 32'h2);
    // R9 pending not visible
    rdchk("R9 pending hidden", 2'd1, 8'h00);
    step(0,0,0, 0,0,0, 1,0,0);
    rdchk("R2 committed low byte", 2'd1, 8'hA5);
    // R3 AND merge
    step(1,2'd2,32'hF0, 0,0,0, 0,0,0);
    step(0,0,0, 1,2'd2,32'h3C, 0,0,0);
    step(0,0,0, 0,0,0, 1,0,0);
    rdchk("R3 and merge", 2'd2, 8'h30);
    // R4 same predicate both ports
    step(1,2'd3,32'h0F, 1,2'd3,32'h3C, 0,0,0);
    step(0,0,0, 0,0,0, 1,0,0);
    rdchk("R4 dual same idx", 2'd3, 8'h0C);
    // R5 different predicates
    step(1,2'd0,32'h11, 1,2'd1,32'h22, 0,0,0);
    chk("R5 mask two bits", {28'd0, pend_mask}, 32'h3);
    step(0,0,0, 0,0,0, 1,0,0);
    rdchk("R5 p0", 2'd0, 8'h11);
    rdchk("R5 p1", 2'd1, 8'h22);
    // R6 only written predicates update
    step(1,2'd0,32'h5A, 0,0,0, 0,0,0);
    step(0,0,0, 0,0,0, 1,0,0);
    chk("R7 mask cleared", {28'd0, pend_mask}, 32'h0);
    rdchk("R6 p0 updated", 2'd0, 8'h5A);
    rdchk("R6 p1 kept", 2'd1, 8'h22);
    rdchk("R6 p3 kept", 2'd3, 8'h0C);
    // R7 fresh packet not ANDed with old
    step(1,2'd0,32'h0F, 0,0,0, 0,0,0);
    step(0,0,0, 0,0,0, 1,0,0);
    rdchk("R7 fresh value", 2'd0, 8'h0F);
    // R8 write in commit cycle
    step(1,2'd2,32'hAA, 0,0,0, 1,0,0);
    chk("R8 mask after", {28'd0, pend_mask}, 32'h0);
    rdchk("R8 commit-cycle write", 2'd2, 8'hAA);
    // R10 invalid write ignored
    step(0,2'd2,32'h00, 0,2'd2,32'h00, 0,0,0);
    chk("R10 mask untouched", {28'd0, pend_mask}, 32'h0);
    step(0,2'd2,32'h00, 0,0,0, 1,0,0);
    rdchk("R10 value kept", 2'd2, 8'hAA);
    // random phase
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0,1), 2'($urandom), $urandom,
           $urandom_range(0,1), 2'($urandom), $urandom | 32'h0000_0081,
           ($urandom_range(0,3) == 0), 2'($urandom), 2'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule